// File: doc/BRIEF.md
# Power-Fail Protected SRAM Bus Interface

This block is a byte-wide memory port in front of a small embedded SRAM array. Its control inputs are active low and follow asynchronous static-RAM conventions: chip enable, output enable and write enable. The port samples them on a system clock and decodes them into four states: deselect, read, write and output-off. A read returns the addressed byte one clock later, together with an enable that a pad ring uses to drive the tri-state data bus.

Two supply flags come from an external comparator. One reports the supply within tolerance. The other reports that the array is running on its back-up source. When either flag shows a fault, the port stops driving the bus and refuses new writes, whatever the control pins do. A write pulse that was already accepted when the fault arrives is finished with the data it last captured. After the supply recovers, reads work again at once. Writes stay blocked until the good indication has held for a programmable number of clock edges.

Top module: `pf_sram_port`

## Requirements
- R1: While eN is high the port does not drive the bus (busDrive low on the next cycle) and the array is not written, whatever gN and wN are.
- R2: A write pulse is the run of cycles with eN and wN both low, whatever gN is. Address and data are captured on every cycle of an accepted pulse, and the array takes the last captured pair on the edge where the pulse ends.
- R3: A read request (eN low, gN low, wN high, supply good) gives busDrive high with dataOut equal to the addressed byte on the cycle after the request edge.
- R4: With eN low and both gN and wN high, busDrive stays low.
- R5: While supplyOk is low or onBackup is high, busDrive is low on the next cycle for any pin combination.
- R6: A write is accepted only if its first cycle falls while writes are allowed. A pulse that starts while blocked changes nothing for its whole length, even if the block is lifted during it.
- R7: If the supply fails during an accepted pulse, the byte captured on the last good cycle is written on the failing edge. Data shown after that is discarded.
- R8: Writes stay blocked until HOLD_CYC consecutive edges have sampled supplyOk high and onBackup low. A pulse starting on the HOLD_CYC-th such edge is rejected, and one starting on the next edge is accepted. Reads are served during this window.
- R9: During and right after reset, busDrive is low and writes are blocked until the hold count of R8 has run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eN | input | 1 | Chip enable, active low |
| gN | input | 1 | Output enable, active low |
| wN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data |
| supplyOk | input | 1 | Supply within tolerance, from the comparator |
| onBackup | input | 1 | Array running from the back-up source |
| dataOut | output | DATA_W | Read data, valid while busDrive is high |
| busDrive | output | 1 | Enable for the tri-state data bus |

## Verification
Some properties are checked on every cycle. The bus is never driven after a supply fault. A driven cycle always follows a sampled read request. An array update always follows a cycle that had the port in write state. A write can only be armed on the first cycle of a pulse. The hold counter saturates only after good supply samples. Other behaviour can only be shown by the bench's scenarios, because it depends on what was stored and read back later. This covers which byte ends up in the array when a pulse is cut by a fault, the exact edge where protection lifts, and a pulse that straddles the release and is still ignored.

// File: rtl/pf_sram_pkg.sv
package pf_sram_pkg;

  // Strobes from the access control to the array datapath
  typedef struct packed {
    logic capture;  // latch address and data of the current write cycle
    logic commit;   // write the latched pair into the array
    logic readEn;   // serve a read of the presented address
  } pfStrobe_t;

  // Decoded pin state
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_OFF   = 2'd3
  } pfAccess_e;

endpackage

// File: rtl/pf_sram_ctrl.sv
module pf_sram_ctrl
  import pf_sram_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      eN,
  input  logic      gN,
  input  logic      wN,
  input  logic      supplyOk,
  input  logic      onBackup,
  output pfStrobe_t strb
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYC);

  pfAccess_e       access;
  logic            supplyGood;
  logic            inWrite;
  logic            prevInWrite;
  logic            pulseStart;
  logic            writeBlocked;
  logic            acceptNow;
  logic            wrActive;
  logic [CNT_W-1:0] goodCnt;

  // Pin decode; E high wins over everything, W low wins over G
  always_comb begin
    if (eN)
      access = ACC_IDLE;
    else if (!wN)
      access = ACC_WRITE;
    else if (!gN)
      access = ACC_READ;
    else
      access = ACC_OFF;
  end

  assign supplyGood   = supplyOk && !onBackup;
  assign inWrite      = (access == ACC_WRITE);
  assign pulseStart   = inWrite && !prevInWrite;
  assign writeBlocked = !supplyGood || (goodCnt != CNT_MAX);
  assign acceptNow    = pulseStart && !writeBlocked;

  // Stability counter for release of write protection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      goodCnt <= '0;
    else if (!supplyGood)
      goodCnt <= '0;
    else if (goodCnt != CNT_MAX)
      goodCnt <= goodCnt + 1'b1;
  end

  // Pulse edge tracking and write-in-progress flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevInWrite <= 1'b0;
      wrActive    <= 1'b0;
    end else begin
      prevInWrite <= inWrite;
      if (acceptNow)
        wrActive <= 1'b1;
      else if (strb.commit)
        wrActive <= 1'b0;
    end
  end

  always_comb begin
    strb.readEn  = (access == ACC_READ) && supplyGood;
    strb.capture = acceptNow || (wrActive && inWrite && supplyGood);
    strb.commit  = wrActive && (!inWrite || !supplyGood);
  end

  // R6
  arm_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrActive) |-> $past(inWrite && !prevInWrite));

  // R8
  release_needs_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodCnt != '0) |-> $past(supplyGood));

  // R7
  fail_ends_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrActive && !supplyGood) |=> !wrActive);

endmodule

// File: rtl/pf_sram_dpath.sv
module pf_sram_dpath
  import pf_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobe_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              busDrive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;

  // Write latch, refreshed on each accepted write cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (strb.capture) begin
      latAddr <= addr;
      latData <= dataIn;
    end
  end

  // Array storage, no reset
  always_ff @(posedge clk) begin
    if (strb.commit)
      mem[latAddr] <= latData;
  end

  // Registered read path and bus enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      busDrive <= 1'b0;
    end else begin
      busDrive <= strb.readEn;
      if (strb.readEn)
        dataOut <= mem[addr];
      else
        dataOut <= '0;
    end
  end

  // R3
  drive_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> $past(strb.readEn));

endmodule

// File: rtl/pf_sram_port.sv
module pf_sram_port
  import pf_sram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eN,
  input  logic              gN,
  input  logic              wN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              supplyOk,
  input  logic              onBackup,
  output logic [DATA_W-1:0] dataOut,
  output logic              busDrive
);

  pfStrobe_t strb;

  pf_sram_ctrl #(
    .HOLD_CYC(HOLD_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .eN      (eN),
    .gN      (gN),
    .wN      (wN),
    .supplyOk(supplyOk),
    .onBackup(onBackup),
    .strb    (strb)
  );

  pf_sram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .busDrive(busDrive)
  );

  // R5
  fail_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk || onBackup) |=> !busDrive);

  // R1
  deselect_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    eN |=> !busDrive);

  // R4
  off_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eN && gN && wN) |=> !busDrive);

  // R2
  commit_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(!eN && !wN));

endmodule

// File: tb/tb_pf_sram_port.sv
`timescale 1ns/100ps
module tb_pf_sram_port;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int HOLD   = 16;
  localparam int NVEC   = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eN = 1'b1, gN = 1'b1, wN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic supplyOk = 1'b1, onBackup = 1'b0;
  logic [DATA_W-1:0] dataOut;
  logic busDrive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  pf_sram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rstN(rstN), .eN(eN), .gN(gN), .wN(wN), .addr(addr),
    .dataIn(dataIn), .supplyOk(supplyOk), .onBackup(onBackup),
    .dataOut(dataOut), .busDrive(busDrive)
  );

  // Row: {eN,gN,wN,supplyOk,onBackup, addr[6], data[8], expDrive, expData[8]}
  localparam logic [27:0] VEC [NVEC] = '{
    {5'b01010, 6'd3,  8'hA5, 1'b0, 8'h00},  // R2 write, G high
    {5'b11110, 6'd0,  8'h00, 1'b0, 8'h00},  // R1 idle, commit edge
    {5'b00110, 6'd3,  8'h00, 1'b1, 8'hA5},  // R3 read back
    {5'b01110, 6'd3,  8'h00, 1'b0, 8'h00},  // R4 E low, G W high
    {5'b00010, 6'd7,  8'h3C, 1'b0, 8'h00},  // R2 write with G low
    {5'b11110, 6'd0,  8'h00, 1'b0, 8'h00},
    {5'b00110, 6'd7,  8'h00, 1'b1, 8'h3C},  // R3
    {5'b10010, 6'd3,  8'hFF, 1'b0, 8'h00},  // R1 E high, G W low
    {5'b11110, 6'd0,  8'h00, 1'b0, 8'h00},
    {5'b00110, 6'd3,  8'h00, 1'b1, 8'hA5},  // R1 no write occurred
    {5'b00111, 6'd3,  8'h00, 1'b0, 8'h00},  // R5 back-up
    {5'b00100, 6'd3,  8'h00, 1'b0, 8'h00},  // R5 supply out of tolerance
    {5'b01010, 6'd3,  8'h00, 1'b0, 8'h00},  // R8 write inside hold window
    {5'b00110, 6'd3,  8'h00, 1'b1, 8'hA5}   // R8 read served, data kept
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply pins at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic tick(input logic e, input logic g, input logic w, input logic ok,
                      input logic bk, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    eN = e; gN = g; wN = w; supplyOk = ok; onBackup = bk; addr = a; dataIn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1, 1, 1, 1, 0, '0, '0);
  endtask

  task automatic readChk(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
    tick(0, 0, 1, 1, 0, a, '0);
    chk(req, {busDrive, dataOut}, {1'b1, exp});
  endtask

  initial begin
    wait (cycles >= 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9 reset state, read pins active during reset
    eN = 0; gN = 0; wN = 1;
    repeat (3) @(negedge clk);
    chk("R9 drive in reset", {busDrive, dataOut}, 9'h000);
    rstN = 1'b1;
    // R9 write right after reset is blocked
    tick(0, 1, 0, 1, 0, 6'd50, 8'h5A);
    idle(HOLD + 2);
    tick(0, 1, 0, 1, 0, 6'd50, 8'h11);
    idle(1);
    readChk("R9 post-reset write blocked then later accepted", 6'd50, 8'h11);

    for (int i = 0; i < NVEC; i++) begin
      tick(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23],
           VEC[i][22:17], VEC[i][16:9]);
      if (VEC[i][8])
        chk($sformatf("vector %0d R3", i), {busDrive, dataOut}, {1'b1, VEC[i][7:0]});
      else
        chk($sformatf("vector %0d R1/R4/R5 no drive", i), {8'h00, busDrive}, 9'h000);
    end
    idle(HOLD + 1);

    // R2 multi-cycle pulse keeps the last captured data
    tick(0, 1, 0, 1, 0, 6'd20, 8'h11);
    tick(0, 1, 0, 1, 0, 6'd20, 8'h22);
    idle(1);
    readChk("R2 last cycle data", 6'd20, 8'h22);

    // R7 fail during accepted pulse completes with captured data
    tick(0, 1, 0, 1, 0, 6'd10, 8'h55);
    tick(0, 1, 0, 0, 0, 6'd10, 8'h99);
    chk("R5 drive during fail", {8'h00, busDrive}, 9'h000);
    idle(HOLD + 1);
    readChk("R7 write completed", 6'd10, 8'h55);

    // R6 pulse that starts blocked and straddles the release
    tick(0, 1, 0, 1, 0, 6'd30, 8'h12);
    idle(1);
    tick(1, 1, 1, 0, 0, '0, '0);
    for (int i = 0; i < HOLD + 3; i++) tick(0, 1, 0, 1, 0, 6'd30, 8'h77);
    idle(1);
    readChk("R6 straddling pulse ignored", 6'd30, 8'h12);

    // R8 boundary: pulse on HOLD-th good edge rejected, on the next accepted
    idle(HOLD + 1);
    tick(0, 1, 0, 1, 0, 6'd40, 8'h01);
    idle(1);
    tick(1, 1, 1, 0, 0, '0, '0);
    idle(HOLD - 1);
    readChk("R8 read in window", 6'd40, 8'h01);
    tick(1, 1, 1, 0, 0, '0, '0);
    idle(HOLD - 1);
    tick(0, 1, 0, 1, 0, 6'd40, 8'hEE);
    idle(1);
    readChk("R8 early write rejected", 6'd40, 8'h01);
    tick(1, 1, 1, 0, 0, '0, '0);
    idle(HOLD);
    tick(0, 1, 0, 1, 0, 6'd40, 8'hEF);
    idle(1);
    readChk("R8 write on next edge accepted", 6'd40, 8'hEF);

    // R5 back-up blocks a write too
    idle(HOLD + 1);
    tick(0, 1, 0, 1, 1, 6'd40, 8'h66);
    idle(HOLD + 1);
    readChk("R5 write in back-up rejected", 6'd40, 8'hEF);

    // R4 read pins change to output-off
    tick(0, 1, 1, 1, 0, 6'd40, '0);
    chk("R4 output off", {8'h00, busDrive}, 9'h000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule